// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing side of a 2048 x 8 byte memory on a two-wire I2C bus. It watches the clock and data lines, both oversampled and synchronised to the system clock. It detects START and STOP conditions, shifts bytes in and out most significant bit first, and pulls the data line low in the ninth clock to acknowledge. Data is pulled low through an active-high output-enable, and the pad is open-drain. The memory itself is a synthesizable register file.

The first byte after START selects the device. Its top nibble must be the type code 1010. The next three bits choose one of eight 256-byte blocks, and the low bit chooses read or write. A write carries a low address byte and then data bytes. Received data is only staged, and it reaches the array when STOP arrives. The STOP then starts a fixed busy period that stands in for the non-volatile write time. Reads come from an internal address counter, so a current-address read, a random read (an address-setting write, then a repeated START) and a sequential read with master acknowledges all use the same path.

Top module: `i2c_mem_slave`

## Requirements
- R1: Reception of a select byte starts only on START (data falling while clock is high), from any state, including in the middle of a transfer.
- R2: Incoming data is sampled on the clock's rising edge, MSB first; the slave changes its data drive only while the clock is low.
- R3: A select byte whose bits [7:4] differ from 4'b1010 gets no acknowledge, and the slave ignores all further bytes until the next START.
- R4: Every accepted received byte (select, address, data) is acknowledged by the slave driving data low during the ninth clock.
- R5: Select byte bits [3:1] load the upper three address bits. In a write, the next byte loads the low eight bits, giving an 11-bit address {block, low}.
- R6: Write data is staged and goes to the array only at STOP. With several data bytes, only the last one is stored, at the address it was received at. A START before STOP discards the staged byte.
- R7: A STOP that commits a byte starts a busy period of BUSY_CYCLES clocks. During this period a select byte is not acknowledged.
- R8: A read returns the byte at the address counter. The counter advances after each byte read or written and wraps from 0x7FF to 0x000, and reading continues while the master acknowledges.
- R9: When the master does not acknowledge a read byte, the slave releases data and ignores the bus until START or STOP.
- R10: STOP ends any transfer, releases data and returns to idle. A STOP after a read starts no busy period.
- R11: After reset, data is released, the address counter is 0 and every memory byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High to pull the data line low (open-drain) |

## Verification
On every cycle, the assertions check four things. Drive changes happen only while the synchronised clock is low. STOP always releases the line. A select byte gets no acknowledge when its type code is wrong or the write timer is running, and it gets one otherwise. The busy period only starts from a commit at STOP. Address composition, the timing of staged commits, sequential wrap at block and array boundaries, discarding on a repeated START, and a current-address read after earlier traffic depend on history across many transfers. The bench's scenarios show these by comparing read-back data against a reference memory that it keeps itself.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_WADR, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK, ST_HOLD
  } state_e;

  typedef enum logic [1:0] {NX_WADR, NX_WDAT, NX_RDAT} next_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2c_mem_cond_det.sv
module i2c_mem_cond_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_o;
      sda_d <= sda_o;
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // data edges only count as conditions while the clock stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_mem_busy.sv
module i2c_mem_busy #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (launch_i)    cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int BLK_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              sda_oe_o,
  output logic              sel_end_o,
  output logic [DATA_W-1:0] sel_byte_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int LOW_W = ADDR_W - BLK_W;
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);

  state_e            state_q;
  next_e             nxt_q;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] rx_q, tx_q;
  logic [ADDR_W-1:0] addr_q, stg_addr_q;
  logic [DATA_W-1:0] stg_data_q;
  logic              stg_vld_q, mack_q;
  logic              byte_end;

  assign byte_end = scl_fall_i && (bit_q == BYTE_END) && !start_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      nxt_q      <= NX_WADR;
      bit_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '1;
      addr_q     <= '0;
      stg_addr_q <= '0;
      stg_data_q <= '0;
      stg_vld_q  <= 1'b0;
      mack_q     <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_SEL;
      bit_q     <= '0;
      stg_vld_q <= 1'b0;
    end else if (stop_i) begin
      state_q   <= ST_IDLE;
      stg_vld_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SEL, ST_WADR, ST_WDAT: begin
          if (scl_rise_i && bit_q != BYTE_END) begin
            rx_q  <= {rx_q[DATA_W-2:0], sda_s_i};
            bit_q <= bit_q + 1'b1;
          end
          if (byte_end) begin
            bit_q <= '0;
            if (state_q == ST_SEL) begin
              if (rx_q[DATA_W-1 -: 4] == DEV_CODE && !busy_i) begin
                addr_q[ADDR_W-1 -: BLK_W] <= rx_q[BLK_W:1];
                nxt_q   <= rx_q[0] ? NX_RDAT : NX_WADR;
                state_q <= ST_ACK;
              end else begin
                state_q <= ST_HOLD;
              end
            end else if (state_q == ST_WADR) begin
              addr_q[LOW_W-1:0] <= rx_q[LOW_W-1:0];
              nxt_q   <= NX_WDAT;
              state_q <= ST_ACK;
            end else begin
              stg_vld_q  <= 1'b1;
              stg_addr_q <= addr_q;
              stg_data_q <= rx_q;
              addr_q     <= addr_q + 1'b1;
              nxt_q      <= NX_WDAT;
              state_q    <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            unique case (nxt_q)
              NX_WADR: state_q <= ST_WADR;
              NX_WDAT: state_q <= ST_WDAT;
              default: begin
                state_q <= ST_RDAT;
                tx_q    <= rdata_i;
                bit_q   <= '0;
              end
            endcase
          end
        end
        ST_RDAT: begin
          if (scl_rise_i) bit_q <= bit_q + 1'b1;
          if (scl_fall_i) begin
            if (bit_q == BYTE_END) begin
              state_q <= ST_RACK;
              addr_q  <= addr_q + 1'b1;
            end else begin
              tx_q <= {tx_q[DATA_W-2:0], 1'b1};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) mack_q <= ~sda_s_i;
          if (scl_fall_i) begin
            if (mack_q) begin
              state_q <= ST_RDAT;
              tx_q    <= rdata_i;
              bit_q   <= '0;
            end else begin
              state_q <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign raddr_o    = addr_q;
  assign we_o       = stop_i && stg_vld_q;
  assign waddr_o    = stg_addr_q;
  assign wdata_o    = stg_data_q;
  assign sda_oe_o   = (state_q == ST_ACK) || (state_q == ST_RDAT && !tx_q[DATA_W-1]);
  assign sel_end_o  = byte_end && (state_q == ST_SEL);
  assign sel_byte_o = rx_q;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int BLK_W       = 3,
  parameter int BUSY_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, mem_we, sel_end;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [DATA_W-1:0] rdata, wdata, sel_byte;

  i2c_mem_cond_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  i2c_mem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_ctrl (
    .clk_i, .rst_ni,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt), .busy_i(busy), .rdata_i(rdata),
    .raddr_o(raddr), .we_o(mem_we), .waddr_o(waddr), .wdata_o(wdata),
    .sda_oe_o, .sel_end_o(sel_end), .sel_byte_o(sel_byte)
  );

  i2c_mem_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i, .rst_ni, .launch_i(mem_we), .busy_o(busy)
  );

  i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );
endmodule

// File: rtl/i2c_mem_checker.sv
module i2c_mem_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s_i,
  input logic              sda_oe_i,
  input logic              stop_i,
  input logic              sel_end_i,
  input logic [DATA_W-1:0] sel_byte_i,
  input logic              busy_i,
  input logic              mem_we_i
);
  assert_oe_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_s_i);

  assert_stop_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  assert_bad_code_nack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_end_i && sel_byte_i[DATA_W-1 -: 4] != 4'b1010 |=> !sda_oe_i);

  assert_busy_nack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_end_i && busy_i |=> !sda_oe_i);

  assert_sel_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_end_i && !busy_i && sel_byte_i[DATA_W-1 -: 4] == 4'b1010 |=> sda_oe_i);

  assert_busy_from_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i) && $past(mem_we_i));
endmodule

bind i2c_mem_slave i2c_mem_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_oe_i(sda_oe_o),
  .stop_i(stop_evt), .sel_end_i(sel_end), .sel_byte_i(sel_byte),
  .busy_i(busy), .mem_we_i(mem_we)
);

// File: tb/i2c_mem_slave_tb_top.sv
module i2c_mem_slave_tb_top;
  localparam int BUSY = 300;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [2048];
  logic [10:0] cur;

  always #4 clk = ~clk;

  i2c_mem_slave #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = ~sda_bus;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~mack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0;
    repeat (2) @(negedge clk);
    sda_m = 1'b1; wq();
  endtask

  function automatic logic [7:0] sel(input logic [10:0] a, input bit rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  task automatic write_byte(input logic [10:0] a, input logic [7:0] d);
    bit k;
    bus_start();
    send_byte(sel(a, 1'b0), k); chk(k, "R4 select ack on write", k, 1);
    send_byte(a[7:0], k);       chk(k, "R5 address byte ack", k, 1);
    send_byte(d, k);            chk(k, "R4 data byte ack", k, 1);
    bus_stop();
    ref_mem[a] = d;
    cur = a + 11'd1;
  endtask

  task automatic set_addr(input logic [10:0] a);
    bit k;
    bus_start();
    send_byte(sel(a, 1'b0), k); chk(k, "R5 dummy write select ack", k, 1);
    send_byte(a[7:0], k);       chk(k, "R5 dummy write address ack", k, 1);
    bus_start();
    send_byte(sel(a, 1'b1), k); chk(k, "R1 repeated START read select ack", k, 1);
    cur = a;
  endtask

  initial begin
    bit k;
    logic [7:0] b;
    logic [10:0] a;
    for (int i = 0; i < 2048; i++) ref_mem[i] = 8'h00;
    cur = '0;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 data released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 data released after reset", sda_oe, 0);

    // R11/R8 current read after reset: address 0, value 0
    bus_start();
    send_byte(sel(11'd0, 1'b1), k); chk(k, "R8 current read select ack", k, 1);
    recv_byte(1'b0, b);             chk(b == 8'h00, "R11 memory zero at counter 0", b, 0);
    bus_stop();
    cur = 11'd1;

    // R3: wrong type code, then following byte ignored
    bus_start();
    send_byte(8'hB0, k); chk(!k, "R3 wrong code not acked", k, 0);
    send_byte(8'hA0, k); chk(!k, "R3 bytes ignored until START", k, 0);
    bus_stop();
    // R1: clocked bytes without START are ignored
    send_byte(8'hA0, k); chk(!k, "R1 no select without START", k, 0);
    bus_stop();

    // R5/R6/R7 write sweep over every block, busy check after each commit
    for (int blk = 0; blk < 8; blk++) begin
      for (int j = 0; j < 4; j++) begin
        a = 11'(blk * 256 + j * 67 + blk);
        write_byte(a, 8'(a * 7 + 3));
        bus_start();
        send_byte(sel(a, 1'b0), k); chk(!k, "R7 select refused while busy", k, 0);
        bus_stop();
        repeat (BUSY + 20) @(negedge clk);
      end
    end
    foreach (a_list[i]) begin
      write_byte(a_list[i], 8'(a_list[i] + 8'h5A));
      repeat (BUSY + 20) @(negedge clk);
    end

    // R8 random reads of the sweep
    for (int blk = 0; blk < 8; blk++) begin
      for (int j = 0; j < 4; j++) begin
        a = 11'(blk * 256 + j * 67 + blk);
        set_addr(a);
        recv_byte(1'b0, b);
        chk(b == ref_mem[a], "R8 R5 R2 random read data", b, ref_mem[a]);
        bus_stop();
      end
    end

    // R8 sequential read across a block boundary
    set_addr(11'h1FE);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, b);
      chk(b == ref_mem[11'h1FE + 11'(i)], "R8 sequential across block", b, ref_mem[11'h1FE + 11'(i)]);
    end
    bus_stop();

    // R8 wrap at top of array
    set_addr(11'h7FE);
    for (int i = 0; i < 4; i++) begin
      a = 11'h7FE + 11'(i);
      recv_byte(i != 3, b);
      chk(b == ref_mem[a], "R8 sequential wrap 7FF to 000", b, ref_mem[a]);
    end
    cur = 11'h002;
    // R9: after master nack the slave leaves data released
    recv_byte(1'b0, b); chk(b == 8'hFF, "R9 released after master nack", b, 8'hFF);
    bus_stop();

    // R8 current-address read follows previous reads
    bus_start();
    send_byte(sel(cur, 1'b1), k); chk(k, "R8 current read select ack", k, 1);
    recv_byte(1'b0, b); chk(b == ref_mem[cur], "R8 current address read", b, ref_mem[cur]);
    bus_stop();
    // R10: no busy after a read STOP
    bus_start();
    send_byte(sel(11'd0, 1'b0), k); chk(k, "R10 no busy after read", k, 1);
    bus_stop();

    // R6: two data bytes, only the last lands at its own address
    bus_start();
    send_byte(sel(11'h345, 1'b0), k);
    send_byte(8'h45, k);
    send_byte(8'hC1, k);
    send_byte(8'hC2, k); chk(k, "R6 second data byte acked", k, 1);
    bus_stop();
    ref_mem[11'h346] = 8'hC2;
    repeat (BUSY + 20) @(negedge clk);
    set_addr(11'h345);
    recv_byte(1'b1, b); chk(b == ref_mem[11'h345], "R6 first staged byte not stored", b, ref_mem[11'h345]);
    recv_byte(1'b0, b); chk(b == 8'hC2, "R6 last byte stored", b, 8'hC2);
    bus_stop();

    // R6: START before STOP discards staged data, no busy follows
    bus_start();
    send_byte(sel(11'h123, 1'b0), k);
    send_byte(8'h23, k);
    send_byte(8'hEE, k);
    bus_start();
    send_byte(sel(11'h123, 1'b1), k);
    recv_byte(1'b0, b);
    bus_stop();
    bus_start();
    send_byte(sel(11'h123, 1'b0), k); chk(k, "R6 discarded write starts no busy", k, 1);
    bus_stop();
    set_addr(11'h123);
    recv_byte(1'b0, b); chk(b == ref_mem[11'h123], "R6 discarded byte not stored", b, ref_mem[11'h123]);
    bus_stop();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  logic [10:0] a_list [4] = '{11'h1FF, 11'h200, 11'h7FF, 11'h000};

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule